// File: doc/BRIEF.md
# Holdover Frequency Word Store

This block sits between a digital PLL's loop filter and its numerically controlled oscillator. It decides which frequency control word the oscillator receives. In normal operation the live word from the loop filter passes straight through. In freerun the oscillator gets a fixed centre word. In holdover it gets a stored word that reflects the frequency the loop held some time before the disturbance.

A period counter advances on a slow system tick enable. Each time it wraps, and while the loop is in normal tracking and reports lock, the block captures the live word. Captures go alternately into two snapshot slots. On holdover the block plays back the slot that is older, which is the one due to be overwritten by the next capture. The more recent slot may already carry the start of the disturbance, so it is not used. Snapshots stay frozen for as long as no capture takes place.

A four-state machine holds the mode: Freerun, Normal, Manual Holdover and Auto Holdover. The transitions are as follows. Any state goes to Freerun when the mode input requests freerun or the reserved code. Any state goes to Manual Holdover on a holdover request. With a normal request, any state goes to Normal when the reference is valid, and to Auto Holdover when it is not. Auto Holdover returns to Normal as soon as the reference-valid flag comes back. The reference-valid flag is produced upstream. It goes low on loss of signal or when the input frequency leaves the ±230 ppm capture range.

Top module: `fword_hold_store`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) sets both snapshot slots to CENTER_WORD, the write pointer to slot 0, the period counter to 0 and the state to Freerun. After that edge, dco_word is CENTER_WORD and holdover and locked are 0.
- R2: mode_sel is sampled at each rising edge, and the new state appears after that edge. The codes are 2'b00 normal, 2'b01 holdover, 2'b10 freerun, and 2'b11 reserved. The reserved code behaves exactly like freerun.
- R3: In the Normal state, dco_word equals live_word in the same cycle.
- R4: In the Freerun state, dco_word equals CENTER_WORD whatever ref_ok, freq_lock, slope_lim and live_word are.
- R5: The period counter counts tick_en cycles from reset and wraps after PERIOD_TICKS of them. A wrap is a capture only if, in that cycle, the state is Normal and locked is 1. A capture writes live_word into the slot named by the write pointer and then toggles the pointer.
- R6: In either holdover state, dco_word equals the slot named by the write pointer. This is the slot not written most recently.
- R7: When mode_sel is normal and ref_ok is 0 at an edge, the state becomes Auto Holdover. It returns to Normal at the first edge where ref_ok is 1.
- R8: holdover is 1 in Manual Holdover and in Auto Holdover, and 0 in the other states.
- R9: locked is 1 only in the Normal state, with freq_lock 1 and slope_lim 0.
- R10: Without a capture, both slots and the write pointer keep their values. This covers holdover, freerun, and normal without lock. A later return to Normal resumes captures at the slot the pointer names.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_en | input | 1 | Slow time-base enable that advances the period counter |
| mode_sel | input | 2 | Requested mode: 00 normal, 01 holdover, 10 freerun, 11 reserved |
| ref_ok | input | 1 | Reference present and within capture range |
| freq_lock | input | 1 | Loop reports frequency lock |
| slope_lim | input | 1 | Phase-slope limiter currently active |
| live_word | input | WORD_W | Live frequency word from the loop filter |
| dco_word | output | WORD_W | Frequency word driving the oscillator |
| holdover | output | 1 | High in either holdover state |
| locked | output | 1 | High when tracking, locked and not slope limited |

## Verification
A corrupted slot or a wrong write pointer stays hidden while the block tracks. It only shows at the ports when holdover is next entered. At that point dco_word shows the wrong snapshot from the first cycle onward. The bench therefore alternates holdover entries between capture bursts and lets live_word change on every cycle, so that each slot carries a distinct value. A wrong state register shows within one cycle as a wrong holdover or locked flag, or as dco_word following the wrong source.

// File: rtl/fwh_pkg.sv
package fwh_pkg;

    typedef enum logic [1:0] {
        ST_FREE      = 2'd0,
        ST_NORM      = 2'd1,
        ST_HOLD_MAN  = 2'd2,
        ST_HOLD_AUTO = 2'd3
    } hold_state_t;

    typedef enum logic [1:0] {
        SRC_CENTER = 2'd0,
        SRC_LIVE   = 2'd1,
        SRC_STORED = 2'd2
    } word_src_t;

    localparam logic [1:0] MODE_NORMAL = 2'b00;
    localparam logic [1:0] MODE_HOLD   = 2'b01;
    localparam logic [1:0] MODE_FREE   = 2'b10;
    localparam logic [1:0] MODE_RSVD   = 2'b11;

endpackage

// File: rtl/fwh_capture_timer.sv
module fwh_capture_timer #(
    parameter int unsigned PERIOD_TICKS = 240
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_en,
    output logic period_pulse
);
    localparam int unsigned CW = (PERIOD_TICKS > 1) ? $clog2(PERIOD_TICKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(PERIOD_TICKS - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (tick_en) begin
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end

    assign period_pulse = tick_en && (cnt_q == LAST);

    // R5
    wrap_to_zero_chk: assert property (@(posedge clk) disable iff (rst)
        $past(period_pulse) |-> (cnt_q == '0));

endmodule

// File: rtl/fwh_snapshot_bank.sv
module fwh_snapshot_bank #(
    parameter int unsigned WORD_W = 24,
    parameter logic [WORD_W-1:0] CENTER_WORD = {1'b1, {(WORD_W-1){1'b0}}}
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_word,
    output logic [WORD_W-1:0] older_word
);
    localparam int unsigned SLOTS = 2;

    logic [SLOTS-1:0][WORD_W-1:0] slot_q;
    logic                         ptr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < SLOTS; i++) begin
                slot_q[i] <= CENTER_WORD;
            end
            ptr_q <= 1'b0;
        end else if (wr_en) begin
            for (int i = 0; i < SLOTS; i++) begin
                if (ptr_q == 1'(i)) begin
                    slot_q[i] <= wr_word;
                end
            end
            ptr_q <= ~ptr_q;
        end
    end

    // The pointer names the slot written least recently.
    assign older_word = slot_q[ptr_q];

    // R10
    slots_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(wr_en) |-> ($stable(slot_q) && $stable(ptr_q)));

    // R5
    ptr_alternates_chk: assert property (@(posedge clk) disable iff (rst)
        $past(wr_en) |-> (ptr_q != $past(ptr_q)));

endmodule

// File: rtl/fwh_hold_fsm.sv
module fwh_hold_fsm
    import fwh_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] mode_sel,
    input  logic       ref_ok,
    input  logic       freq_lock,
    input  logic       slope_lim,
    output logic       holdover,
    output logic       locked,
    output word_src_t  word_src
);
    hold_state_t state_q;
    hold_state_t state_d;

    always_comb begin
        unique case (mode_sel)
            MODE_NORMAL: state_d = ref_ok ? ST_NORM : ST_HOLD_AUTO;
            MODE_HOLD:   state_d = ST_HOLD_MAN;
            default:     state_d = ST_FREE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_FREE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        holdover = 1'b0;
        locked   = 1'b0;
        word_src = SRC_CENTER;
        unique case (state_q)
            ST_FREE: begin
                word_src = SRC_CENTER;
            end
            ST_NORM: begin
                word_src = SRC_LIVE;
                locked   = freq_lock && !slope_lim;
            end
            ST_HOLD_MAN, ST_HOLD_AUTO: begin
                word_src = SRC_STORED;
                holdover = 1'b1;
            end
            default: begin
                word_src = SRC_CENTER;
            end
        endcase
    end

    // R7
    auto_entry_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(mode_sel) == MODE_NORMAL && !$past(ref_ok)) |-> holdover);

    // R2
    reserved_as_free_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(mode_sel) == MODE_RSVD) |-> (!holdover && !locked));

    // R9
    lock_needs_track_chk: assert property (@(posedge clk) disable iff (rst)
        locked |-> ($past(mode_sel) == MODE_NORMAL && $past(ref_ok) && !slope_lim));

endmodule

// File: rtl/fword_hold_store.sv
module fword_hold_store
    import fwh_pkg::*;
#(
    parameter int unsigned WORD_W       = 24,
    parameter int unsigned PERIOD_TICKS = 240,
    parameter logic [WORD_W-1:0] CENTER_WORD = {1'b1, {(WORD_W-1){1'b0}}}
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  logic [1:0]        mode_sel,
    input  logic              ref_ok,
    input  logic              freq_lock,
    input  logic              slope_lim,
    input  logic [WORD_W-1:0] live_word,
    output logic [WORD_W-1:0] dco_word,
    output logic              holdover,
    output logic              locked
);
    logic              period_pulse;
    logic              capture;
    logic [WORD_W-1:0] older_word;
    word_src_t         word_src;

    fwh_capture_timer #(.PERIOD_TICKS(PERIOD_TICKS)) u_timer (
        .clk          (clk),
        .rst          (rst),
        .tick_en      (tick_en),
        .period_pulse (period_pulse)
    );

    fwh_hold_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .mode_sel  (mode_sel),
        .ref_ok    (ref_ok),
        .freq_lock (freq_lock),
        .slope_lim (slope_lim),
        .holdover  (holdover),
        .locked    (locked),
        .word_src  (word_src)
    );

    // locked is only ever high in the tracking state
    assign capture = period_pulse && locked;

    fwh_snapshot_bank #(.WORD_W(WORD_W), .CENTER_WORD(CENTER_WORD)) u_bank (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (capture),
        .wr_word    (live_word),
        .older_word (older_word)
    );

    always_comb begin
        unique case (word_src)
            SRC_LIVE:   dco_word = live_word;
            SRC_STORED: dco_word = older_word;
            default:    dco_word = CENTER_WORD;
        endcase
    end

    // R4
    freerun_center_chk: assert property (@(posedge clk) disable iff (rst)
        $past(mode_sel[1]) |-> (dco_word == CENTER_WORD));

    // R6
    hold_word_steady_chk: assert property (@(posedge clk) disable iff (rst)
        (holdover && $past(holdover)) |-> $stable(dco_word));

endmodule

// File: tb/fword_hold_store_test.sv
module fword_hold_store_test;

    localparam int unsigned W   = 16;
    localparam int unsigned PER = 4;
    localparam logic [W-1:0] CTR = 16'h8000;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         tick_en = 1'b0;
    logic [1:0]   mode_sel = 2'b10;
    logic         ref_ok = 1'b0;
    logic         freq_lock = 1'b0;
    logic         slope_lim = 1'b0;
    logic [W-1:0] live_word = '0;
    logic [W-1:0] dco_word;
    logic         holdover;
    logic         locked;

    int checks = 0;
    int fails  = 0;
    string ph = "R1";

    // behavioural model: 0 free, 1 normal, 2 manual hold, 3 auto hold
    int           m_st = 0;
    int           m_cnt = 0;
    int           m_ptr = 0;
    logic [W-1:0] m_slot [2];

    always #4 clk = ~clk;

    fword_hold_store #(.WORD_W(W), .PERIOD_TICKS(PER), .CENTER_WORD(CTR)) uut (
        .clk(clk), .rst(rst), .tick_en(tick_en), .mode_sel(mode_sel),
        .ref_ok(ref_ok), .freq_lock(freq_lock), .slope_lim(slope_lim),
        .live_word(live_word), .dco_word(dco_word), .holdover(holdover),
        .locked(locked)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        logic [W-1:0] ew;
        bit           eh, el, fire, lk;
        string        wt;
        @(posedge clk);
        if (rst) begin
            m_st = 0; m_cnt = 0; m_ptr = 0;
            m_slot[0] = CTR; m_slot[1] = CTR;
        end else begin
            fire = tick_en && (m_cnt == PER - 1);
            lk   = (m_st == 1) && freq_lock && !slope_lim;
            if (fire && lk) begin
                m_slot[m_ptr] = live_word;
                m_ptr = 1 - m_ptr;
            end
            if (tick_en) m_cnt = fire ? 0 : m_cnt + 1;
            if (mode_sel == 2'b00)      m_st = ref_ok ? 1 : 3;
            else if (mode_sel == 2'b01) m_st = 2;
            else                        m_st = 0;
        end
        @(negedge clk);
        if (m_st == 1)      begin ew = live_word;     wt = "R3"; end
        else if (m_st == 0) begin ew = CTR;           wt = "R4"; end
        else                begin ew = m_slot[m_ptr]; wt = "R6"; end
        eh = (m_st >= 2);
        el = (m_st == 1) && freq_lock && !slope_lim;
        check(dco_word == ew, {ph, "/", wt, " dco_word"}, int'(dco_word), int'(ew));
        check(holdover == eh, {ph, "/R8 holdover"}, int'(holdover), int'(eh));
        check(locked == el,   {ph, "/R9 locked"}, int'(locked), int'(el));
    endtask

    task automatic run(input int n, input logic [1:0] md, input bit rf,
                       input bit fl, input bit sl, input bit rnd);
        for (int i = 0; i < n; i++) begin
            mode_sel  = md;
            ref_ok    = rnd ? 1'($urandom) : rf;
            freq_lock = fl;
            slope_lim = sl;
            tick_en   = (i % 2 == 0);
            live_word = W'($urandom);
            step();
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        // R1: reset state
        rst = 1'b1;
        ph = "R1";
        run(5, 2'b00, 1'b1, 1'b1, 1'b0, 1'b0);
        check(dco_word == CTR, "R1 reset dco_word", int'(dco_word), int'(CTR));
        rst = 1'b0;
        // hold right after reset: both slots are centre
        ph = "R1";
        run(3, 2'b01, 1'b1, 1'b1, 1'b0, 1'b0);
        ph = "R4";
        run(20, 2'b10, 1'b1, 1'b1, 1'b0, 1'b1);
        ph = "R5";
        run(21, 2'b00, 1'b1, 1'b1, 1'b0, 1'b0);
        ph = "R6";
        run(12, 2'b01, 1'b1, 1'b1, 1'b0, 1'b0);
        ph = "R5";
        run(9, 2'b00, 1'b1, 1'b1, 1'b0, 1'b0);
        ph = "R6";
        run(6, 2'b01, 1'b0, 1'b0, 1'b0, 1'b0);
        // R10: tracking without lock must not capture
        ph = "R10";
        run(30, 2'b00, 1'b1, 1'b1, 1'b1, 1'b0);
        run(30, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0);
        ph = "R10";
        run(8, 2'b01, 1'b1, 1'b1, 1'b0, 1'b0);
        ph = "R7";
        run(13, 2'b00, 1'b1, 1'b1, 1'b0, 1'b0);
        run(10, 2'b00, 1'b0, 1'b1, 1'b0, 1'b0);
        run(17, 2'b00, 1'b1, 1'b1, 1'b0, 1'b0);
        run(5, 2'b00, 1'b0, 1'b1, 1'b0, 1'b0);
        ph = "R2";
        run(12, 2'b11, 1'b1, 1'b1, 1'b0, 1'b0);
        run(4, 2'b01, 1'b1, 1'b1, 1'b0, 1'b0);
        ph = "R9";
        for (int i = 0; i < 40; i++) begin
            run(1, 2'b00, 1'b1, 1'($urandom), 1'($urandom), 1'b0);
        end
        ph = "R2";
        for (int i = 0; i < 600; i++) begin
            mode_sel  = 2'($urandom);
            ref_ok    = ($urandom % 4) != 0;
            freq_lock = ($urandom % 4) != 0;
            slope_lim = ($urandom % 5) == 0;
            tick_en   = 1'($urandom);
            live_word = W'($urandom);
            step();
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule